// File: doc/BRIEF.md
# Scratchpad Line Memory

This block is a small on-chip scratchpad that software manages directly. It has four 12-bit lines. Each line holds two 6-bit words, so there are eight words in total. There are no tags and no misses, and every access takes the same number of cycles. The block transfers data only through a fixed register pair, R6 and R7. The surrounding datapath presents the current values of those two registers. The block returns write-back data and enables for them.

Each access is a 9-bit command qualified by a valid strobe. Bits [8:6] hold the opcode, bit [5] chooses single or double access, and bits [4:0] hold the word or line field.

- A double access moves a whole line. The upper half of the line goes with R6 and the lower half with R7.
- A single access moves one word, and only R6 takes part.

Top module: `scratch_line_mem`

## Requirements
- R1: While rst_ni is low, all four lines are cleared to zero and both write enables are low. A load issued after reset returns zero.
- R2: A valid command with opcode 3'b101 (load) and bit [5]=1 reads the line selected by field bits [1:0]. One cycle later, r6_wdata_o carries bits [11:6] of that line and r7_wdata_o carries bits [5:0], and both enables are high.
- R3: A valid load with bit [5]=0 reads the word selected by field bits [2:0]. Word 2k is the upper half of line k and word 2k+1 is its lower half. One cycle later, r6_wdata_o carries that word, r6_we_o is high and r7_we_o is low.
- R4: A valid command with opcode 3'b110 (store) and bit [5]=1 writes r6_i into the upper half and r7_i into the lower half of the line selected by field bits [1:0].
- R5: A valid store with bit [5]=0 writes r6_i into the word selected by field bits [2:0]. The other half of that line keeps its value.
- R6: Field bits above those that select a word (single access) or a line (double access) are ignored.
- R7: A command with cmd_valid_i low, or with any opcode other than 3'b101 or 3'b110, changes no storage and raises no enable in the following cycle.
- R8: Write enables appear exactly one cycle after a valid load and last one cycle. A store never raises an enable.
- R9: A load issued in the cycle right after a store to the same location returns the newly stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 9 | Opcode [8:6], double flag [5], word/line field [4:0] |
| r6_i | input | 6 | Current value of R6 (store source) |
| r7_i | input | 6 | Current value of R7 (store source) |
| r6_wdata_o | output | 6 | Load data for R6 |
| r6_we_o | output | 1 | R6 write-back enable |
| r7_wdata_o | output | 6 | Load data for R7 |
| r7_we_o | output | 1 | R7 write-back enable |

## Verification
A corrupted line or a store to the wrong half stays invisible until a load reads that location. A load then shows the damage on the write-back data one cycle after it is issued. For this reason, every store in the bench is followed by loads that cover both halves of the line and the neighbouring lines. A wrong decode of opcode or access size shows sooner, as a wrong enable pattern in the cycle right after the command.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_LOAD  = 3'b101;
  localparam logic [OP_W-1:0] OP_STORE = 3'b110;
endpackage

// File: rtl/scratch_decode.sv
module scratch_decode
  import scratch_pkg::*;
#(
  parameter int unsigned CMD_W   = 9,
  parameter int unsigned FIELD_W = 5,
  parameter int unsigned LINE_AW = 2
) (
  input  logic               valid_i,
  input  logic [CMD_W-1:0]   cmd_i,
  output logic               ld_o,
  output logic               st_o,
  output logic               dbl_o,
  output logic [LINE_AW-1:0] line_o,
  output logic               lo_half_o
);
  localparam int unsigned DBL_BIT = FIELD_W;
  localparam int unsigned OP_LSB  = FIELD_W + 1;

  logic [OP_W-1:0]    op;
  logic [FIELD_W-1:0] field;
  logic               unused_field;

  assign op    = cmd_i[OP_LSB +: OP_W];
  assign field = cmd_i[FIELD_W-1:0];
  assign unused_field = ^field[FIELD_W-1:LINE_AW+1];

  always_comb begin
    ld_o  = valid_i && (op == OP_LOAD);
    st_o  = valid_i && (op == OP_STORE);
    dbl_o = cmd_i[DBL_BIT];
    if (dbl_o) begin
      line_o    = field[LINE_AW-1:0];
      lo_half_o = 1'b0;
    end else begin
      line_o    = field[LINE_AW:1];
      lo_half_o = field[0];
    end
  end
endmodule

// File: rtl/scratch_array.sv
module scratch_array #(
  parameter int unsigned WORD_W    = 6,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned LINE_AW   = $clog2(NUM_LINES),
  parameter int unsigned LINE_W    = 2 * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               st_i,
  input  logic               dbl_i,
  input  logic               lo_half_i,
  input  logic [LINE_AW-1:0] line_i,
  input  logic [WORD_W-1:0]  hi_data_i,
  input  logic [WORD_W-1:0]  lo_data_i,
  output logic [LINE_W-1:0]  rd_line_o
);
  logic [LINE_W-1:0] lines_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic sel;
    assign sel = st_i && (line_i == LINE_AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lines_q[g] <= '0;
      end else if (sel) begin
        if (dbl_i)          lines_q[g] <= {hi_data_i, lo_data_i};
        else if (lo_half_i) lines_q[g][WORD_W-1:0] <= hi_data_i;
        else                lines_q[g][LINE_W-1:WORD_W] <= hi_data_i;
      end
    end
  end

  assign rd_line_o = lines_q[line_i];
endmodule

// File: rtl/scratch_rsp.sv
module scratch_rsp #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned LINE_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              dbl_i,
  input  logic              lo_half_i,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic [WORD_W-1:0] hi_data_o,
  output logic              hi_we_o,
  output logic [WORD_W-1:0] lo_data_o,
  output logic              lo_we_o
);
  logic [WORD_W-1:0] upper, lower, hi_next;

  assign upper   = rd_line_i[LINE_W-1:WORD_W];
  assign lower   = rd_line_i[WORD_W-1:0];
  assign hi_next = (!dbl_i && lo_half_i) ? lower : upper;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_data_o <= '0;
      lo_data_o <= '0;
      hi_we_o   <= 1'b0;
      lo_we_o   <= 1'b0;
    end else begin
      hi_we_o <= ld_i;
      lo_we_o <= ld_i && dbl_i;
      if (ld_i) begin
        hi_data_o <= hi_next;
        lo_data_o <= lower;
      end
    end
  end
endmodule

// File: rtl/scratch_line_mem.sv
module scratch_line_mem #(
  parameter int unsigned WORD_W    = 6,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned CMD_W     = FIELD_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [WORD_W-1:0] r6_i,
  input  logic [WORD_W-1:0] r7_i,
  output logic [WORD_W-1:0] r6_wdata_o,
  output logic              r6_we_o,
  output logic [WORD_W-1:0] r7_wdata_o,
  output logic              r7_we_o
);
  localparam int unsigned LINE_AW = $clog2(NUM_LINES);
  localparam int unsigned LINE_W  = 2 * WORD_W;

  logic               ld, st, dbl, lo_half;
  logic [LINE_AW-1:0] line;
  logic [LINE_W-1:0]  rd_line;

  scratch_decode #(.CMD_W(CMD_W), .FIELD_W(FIELD_W), .LINE_AW(LINE_AW)) u_dec (
    .valid_i(cmd_valid_i), .cmd_i(cmd_i), .ld_o(ld), .st_o(st),
    .dbl_o(dbl), .line_o(line), .lo_half_o(lo_half)
  );

  scratch_array #(.WORD_W(WORD_W), .NUM_LINES(NUM_LINES), .LINE_AW(LINE_AW),
                  .LINE_W(LINE_W)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .dbl_i(dbl),
    .lo_half_i(lo_half), .line_i(line), .hi_data_i(r6_i),
    .lo_data_i(r7_i), .rd_line_o(rd_line)
  );

  scratch_rsp #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld), .dbl_i(dbl),
    .lo_half_i(lo_half), .rd_line_i(rd_line), .hi_data_o(r6_wdata_o),
    .hi_we_o(r6_we_o), .lo_data_o(r7_wdata_o), .lo_we_o(r7_we_o)
  );
endmodule

// File: rtl/scratch_line_mem_chk.sv
module scratch_line_mem_chk #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned CMD_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic              r6_we_o,
  input logic              r7_we_o
);
  logic is_ld, is_st, dbl;
  assign is_ld = cmd_valid_i && (cmd_i[CMD_W-1 -: 3] == 3'b101);
  assign is_st = cmd_valid_i && (cmd_i[CMD_W-1 -: 3] == 3'b110);
  assign dbl   = cmd_i[CMD_W-4];

  AST_DBL_LOAD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ld && dbl |=> r6_we_o && r7_we_o); // R2
  AST_SGL_LOAD_R6_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ld && !dbl |=> r6_we_o && !r7_we_o); // R3
  AST_NOP_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ld && !is_st |=> !r6_we_o && !r7_we_o); // R7
  AST_STORE_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_st |=> !r6_we_o && !r7_we_o); // R8
  AST_R7_NEEDS_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r7_we_o |-> r6_we_o); // R2
endmodule

bind scratch_line_mem scratch_line_mem_chk #(.WORD_W(WORD_W), .CMD_W(CMD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .r6_we_o(r6_we_o), .r7_we_o(r7_we_o)
);

// File: tb/tb_scratch_line_mem.sv
module tb_scratch_line_mem;
  localparam logic [2:0] LD = 3'b101, ST = 3'b110;

  typedef struct packed {
    logic       we6;
    logic       we7;
    logic [5:0] d6;
    logic [5:0] d7;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [8:0] cmd = '0;
  logic [5:0] r6 = '0, r7 = '0;
  logic [5:0] r6_wd, r7_wd;
  logic       r6_we, r7_we;

  int    vecs = 0, errs = 0;
  exp_t  expq[$];
  string reqq[$];
  logic [5:0] model [8];

  always #10 clk = ~clk;

  scratch_line_mem dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld), .cmd_i(cmd),
    .r6_i(r6), .r7_i(r7), .r6_wdata_o(r6_wd), .r6_we_o(r6_we),
    .r7_wdata_o(r7_wd), .r7_we_o(r7_we)
  );

  task automatic drive(input logic v, input logic [2:0] op, input logic d,
                       input logic [4:0] f, input logic [5:0] a6,
                       input logic [5:0] a7, input string req);
    exp_t e;
    @(negedge clk);
    #1;
    vld = v; cmd = {op, d, f}; r6 = a6; r7 = a7;
    e = '0;
    if (v && op == LD) begin
      e.we6 = 1'b1;
      if (d) begin
        e.we7 = 1'b1;
        e.d6  = model[{f[1:0], 1'b0}];
        e.d7  = model[{f[1:0], 1'b1}];
      end else begin
        e.d6 = model[f[2:0]];
      end
    end else if (v && op == ST) begin
      if (d) begin
        model[{f[1:0], 1'b0}] = a6;
        model[{f[1:0], 1'b1}] = a7;
      end else begin
        model[f[2:0]] = a6;
      end
    end
    expq.push_back(e);
    reqq.push_back(req);
  endtask

  task automatic idle(input string req);
    drive(1'b0, 3'b000, 1'b0, 5'd0, 6'd0, 6'd0, req);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (expq.size() > 0) begin
        exp_t  e;
        string r;
        logic  bad;
        e = expq.pop_front();
        r = reqq.pop_front();
        vecs++;
        bad = (r6_we !== e.we6) || (r7_we !== e.we7) ||
              (e.we6 && r6_wd !== e.d6) || (e.we7 && r7_wd !== e.d7);
        if (bad) begin
          errs++;
          $display("FAIL %s: got we6=%b we7=%b d6=%h d7=%h expected we6=%b we7=%b d6=%h d7=%h",
                   r, r6_we, r7_we, r6_wd, r7_wd, e.we6, e.we7, e.d6, e.d7);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: enables low during reset
    vecs++;
    if (r6_we !== 1'b0 || r7_we !== 1'b0) begin
      errs++;
      $display("FAIL R1: got we6=%b we7=%b expected 0 0", r6_we, r7_we);
    end
    rst_n = 1'b1;
    idle("R1");
    for (int l = 0; l < 4; l++) drive(1'b1, LD, 1'b1, 5'(l), 6'd0, 6'd0, "R1");
    // R4 double store, then R9 immediate load
    drive(1'b1, ST, 1'b1, 5'd2, 6'h2A, 6'h15, "R4");
    drive(1'b1, LD, 1'b1, 5'd2, 6'd0, 6'd0, "R9");
    drive(1'b1, ST, 1'b1, 5'd0, 6'h3F, 6'h01, "R4");
    drive(1'b1, LD, 1'b1, 5'd1, 6'd0, 6'd0, "R2");
    drive(1'b1, LD, 1'b1, 5'd0, 6'd0, 6'd0, "R2");
    // R5 single store into lower half of line 2
    drive(1'b1, ST, 1'b0, 5'd5, 6'h3C, 6'h07, "R5");
    drive(1'b1, LD, 1'b1, 5'd2, 6'd0, 6'd0, "R5");
    drive(1'b1, LD, 1'b0, 5'd4, 6'd0, 6'd0, "R3");
    drive(1'b1, LD, 1'b0, 5'd5, 6'd0, 6'd0, "R3");
    drive(1'b1, ST, 1'b0, 5'd6, 6'h11, 6'h22, "R5");
    drive(1'b1, LD, 1'b1, 5'd3, 6'd0, 6'd0, "R5");
    // R6 upper field bits ignored
    drive(1'b1, ST, 1'b0, 5'b11001, 6'h19, 6'h00, "R6");
    drive(1'b1, LD, 1'b0, 5'b00001, 6'd0, 6'd0, "R6");
    drive(1'b1, LD, 1'b1, 5'b11111, 6'd0, 6'd0, "R6");
    drive(1'b1, LD, 1'b0, 5'b10110, 6'd0, 6'd0, "R6");
    drive(1'b1, ST, 1'b1, 5'b10101, 6'h05, 6'h06, "R6");
    drive(1'b1, LD, 1'b1, 5'd1, 6'd0, 6'd0, "R6");
    // R7 ignored commands, then readback
    drive(1'b1, 3'b000, 1'b1, 5'd0, 6'h33, 6'h33, "R7");
    drive(1'b1, 3'b111, 1'b1, 5'd1, 6'h33, 6'h33, "R7");
    drive(1'b1, 3'b100, 1'b0, 5'd4, 6'h33, 6'h33, "R7");
    drive(1'b0, ST, 1'b1, 5'd3, 6'h33, 6'h33, "R7");
    drive(1'b0, LD, 1'b1, 5'd3, 6'd0, 6'd0, "R7");
    for (int l = 0; l < 4; l++) drive(1'b1, LD, 1'b1, 5'(l), 6'd0, 6'd0, "R7");
    // R8 back-to-back mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 120; i++) begin
      logic [2:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0, 2'd1: op = LD;
        2'd2:       op = ST;
        default:    op = lfsr[4:2];
      endcase
      drive(lfsr[5] | lfsr[6], op, lfsr[7], lfsr[12:8], lfsr[15:10], lfsr[9:4], "R8");
    end
    for (int l = 0; l < 4; l++) drive(1'b1, LD, 1'b1, 5'(l), 6'd0, 6'd0, "R8");
    idle("R8");
    idle("R8");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule